// File: doc/BRIEF.md
# Two-Wire Presence-Detect Slave

This block is the slave side of a two-wire serial bus (clock line plus open-drain data line) that exposes a 256-byte configuration array on a memory module. Both bus lines are brought into a faster system-clock domain through synchronizers. All bus decisions are made there from the detected clock edges and from the bus conditions, which are a data transition while the bus clock is high.

A host opens every transaction with a start condition and sends a device byte: seven address bits followed by a direction bit. When the address matches, a write transaction loads a word pointer from its first byte and stores each following byte at the pointer. A read transaction returns bytes from the pointer for as long as the host acknowledges them. A stop condition closes any transaction and raises the standby output. The block drives only a pull-down enable for the data line, so the pad and the pull-up sit outside it.

Top module: `tw_pd_slave`

## Requirements
- R1: After reset the block does not pull the data line (`sda_pull_o` = 0) and reports standby (`standby_o` = 1).
- R2: Until a start condition is seen, clocked bus traffic produces no acknowledge and `standby_o` stays 1. The pull-down is never active while `standby_o` is 1.
- R3: A start condition (data falling while clock is high) clears `standby_o`. A following device byte, sent MSB first, whose upper seven bits equal `DEV_ADDR` is acknowledged by pulling the data line low during the ninth clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read.
- R4: A device byte with a different address gets no acknowledge. Every later byte is then ignored, with no acknowledge and no write, until the next start.
- R5: In a write transaction the first byte after the device byte loads the word pointer. Each later byte is stored at the pointer, after which the pointer advances. Every one of these bytes is acknowledged.
- R6: In a read transaction the block sends the byte at the pointer MSB first and advances the pointer once per byte sent. The pointer wraps from 255 to 0, both when reading and when writing.
- R7: A host acknowledge (data low during the ninth clock) after a read byte makes the block send the next byte. Without that acknowledge the block leaves the line released for all later clocks until a start or stop.
- R8: A stop condition (data rising while clock is high) sets `standby_o` to 1 and releases the data line.
- R9: A start condition in the middle of a transaction (repeated start) restarts device-byte reception, releases the line and does not raise `standby_o`.
- R10: `sda_pull_o` changes only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 enables the open-drain pull-down on the data line |
| standby_o | output | 1 | 1 while the block rests in standby after reset or a stop |

## Verification
The main function is driven with several byte patterns. Writes of mixed bit patterns (0x5A, 0xC3, 0x0F) show that bit order and pointer advance are right. A write that crosses address 255 and is read back, including a one-byte read at address 0, shows the pointer wrap. A read ended by a host non-acknowledge, then clocked on, shows that the block falls silent. Untriggered traffic before any start and a foreign device address are each followed by checks that no acknowledge appears and that no stored byte was changed, which separates real ignoring from mis-decoded writes. A repeated start in the middle of a write tells restart handling apart from a stop.

// File: rtl/tw_pkg.sv
// Shared types of the two-wire presence-detect slave.
// Assumes nothing beyond the standard SystemVerilog enum and struct rules.
package tw_pkg;

    // Controller states of the byte engine.
    typedef enum logic [2:0] {
        ST_IDLE,      // standby, waiting for a start
        ST_RX,        // shifting in a byte on clock rises
        ST_ACK_ARM,   // byte taken, pull low at next clock fall
        ST_ACK,       // holding acknowledge through the ninth clock
        ST_TX,        // shifting out a byte on clock falls
        ST_RACK,      // line released, sampling host acknowledge
        ST_RACK_END,  // host acknowledged, next byte starts at fall
        ST_WAIT       // off the bus until start or stop
    } tw_state_t;

    // Meaning of the byte currently received.
    typedef enum logic [1:0] {
        PH_DEV,       // device address plus direction bit
        PH_WORD,      // word pointer load
        PH_DATA       // write data
    } tw_phase_t;

    // Bus events seen in the system-clock domain.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } tw_bus_ev_t;

endpackage

// File: rtl/tw_line_sync.sv
// Multi-stage synchronizer for a group of asynchronous single-bit lines.
// Assumes each line is an independent level; the reset value is all ones,
// which matches an idle pulled-up bus.
module tw_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            // First stage: capture the raw pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= '1;
                else        chain_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stages: pass the level one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[k] <= '1;
                else        chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_cond_detect.sv
// Derives clock edges and start/stop conditions from synchronized lines.
// Assumes both inputs come out of the same synchronizer, so their relative
// order is kept. A condition needs the clock high in both compared samples.
module tw_cond_detect
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    output tw_bus_ev_t ev_o
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Keep the previous sample of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    // Classify the current sample pair into bus events.
    always_comb begin
        ev_o.scl_rise = scl_s & ~scl_prev_q;
        ev_o.scl_fall = ~scl_s & scl_prev_q;
        ev_o.start    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
        ev_o.stop     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
        ev_o.sda      = sda_s;
    end

endmodule

// File: rtl/tw_regfile.sv
// Byte-wide register array with one synchronous write and one
// combinational read port. Assumes the address is always below DEPTH.
// The contents have no reset.
module tw_regfile #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    logic [DW-1:0] mem_q [DEPTH];

    // Store one byte when the engine commits a write.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/tw_slave_fsm.sv
// Byte engine of the slave: address match, acknowledge, pointer handling,
// write commit and read shifting. Assumes bus events from tw_cond_detect
// and a bus clock low phase of at least a few system clocks, so every
// change of the pull-down lands while the bus clock is low.
// Start and stop take priority over every state.
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         DEPTH    = 256,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tw_bus_ev_t    ev_i,
    input  logic [7:0]    rd_data_i,
    output logic [AW-1:0] ptr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          sda_pull_o,
    output logic          standby_o
);

    tw_state_t     state_q;
    tw_phase_t     phase_q;
    logic [2:0]    bit_cnt_q;
    logic [6:0]    rx_sh_q;
    logic [6:0]    tx_sh_q;
    logic          is_read_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_inc;
    logic [7:0]    rx_byte;

    // Next pointer value with wrap at the top of the array.
    always_comb begin
        if (ptr_q == AW'(DEPTH - 1)) ptr_inc = '0;
        else                         ptr_inc = ptr_q + 1'b1;
    end

    assign rx_byte = {rx_sh_q, ev_i.sda};
    assign ptr_o   = ptr_q;

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_DEV;
            bit_cnt_q  <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            is_read_q  <= 1'b0;
            ptr_q      <= '0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            sda_pull_o <= 1'b0;
            standby_o  <= 1'b1;
        end else begin
            wr_en_o <= 1'b0;
            if (ev_i.start) begin
                state_q    <= ST_RX;
                phase_q    <= PH_DEV;
                bit_cnt_q  <= '0;
                sda_pull_o <= 1'b0;
                standby_o  <= 1'b0;
            end else if (ev_i.stop) begin
                state_q    <= ST_IDLE;
                sda_pull_o <= 1'b0;
                standby_o  <= 1'b1;
            end else begin
                case (state_q)
                    ST_RX: begin
                        if (ev_i.scl_rise) begin
                            rx_sh_q <= {rx_sh_q[5:0], ev_i.sda};
                            if (bit_cnt_q == 3'd7) begin
                                bit_cnt_q <= '0;
                                case (phase_q)
                                    PH_DEV: begin
                                        if (rx_byte[7:1] == DEV_ADDR) begin
                                            is_read_q <= rx_byte[0];
                                            state_q   <= ST_ACK_ARM;
                                        end else begin
                                            state_q   <= ST_WAIT;
                                        end
                                    end
                                    PH_WORD: begin
                                        ptr_q   <= rx_byte[AW-1:0];
                                        phase_q <= PH_DATA;
                                        state_q <= ST_ACK_ARM;
                                    end
                                    default: begin
                                        wr_en_o   <= 1'b1;
                                        wr_addr_o <= ptr_q;
                                        wr_data_o <= rx_byte;
                                        ptr_q     <= ptr_inc;
                                        state_q   <= ST_ACK_ARM;
                                    end
                                endcase
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ACK_ARM: begin
                        if (ev_i.scl_fall) begin
                            sda_pull_o <= 1'b1;
                            state_q    <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (ev_i.scl_fall) begin
                            bit_cnt_q <= '0;
                            if (phase_q == PH_DEV && is_read_q) begin
                                tx_sh_q    <= rd_data_i[6:0];
                                sda_pull_o <= ~rd_data_i[7];
                                ptr_q      <= ptr_inc;
                                state_q    <= ST_TX;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state_q    <= ST_RX;
                                if (phase_q == PH_DEV) phase_q <= PH_WORD;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_i.scl_fall) begin
                            if (bit_cnt_q == 3'd7) begin
                                sda_pull_o <= 1'b0;
                                state_q    <= ST_RACK;
                            end else begin
                                bit_cnt_q  <= bit_cnt_q + 1'b1;
                                sda_pull_o <= ~tx_sh_q[6];
                                tx_sh_q    <= {tx_sh_q[5:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev_i.scl_rise) begin
                            if (ev_i.sda) state_q <= ST_WAIT;
                            else          state_q <= ST_RACK_END;
                        end
                    end
                    ST_RACK_END: begin
                        if (ev_i.scl_fall) begin
                            bit_cnt_q  <= '0;
                            tx_sh_q    <= rd_data_i[6:0];
                            sda_pull_o <= ~rd_data_i[7];
                            ptr_q      <= ptr_inc;
                            state_q    <= ST_TX;
                        end
                    end
                    default: begin
                        // Idle and wait states ignore all bus traffic.
                        sda_pull_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_pd_slave.sv
// Top of the two-wire presence-detect slave. Synchronizes the bus lines,
// detects bus events, runs the byte engine and holds the byte array.
// Assumes the system clock runs at least 8 times faster than the bus clock
// and that an external open-drain pad turns sda_pull_o into a low level.
module tw_pd_slave
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_DEPTH   = 256,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(MEM_DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic standby_o
);

    logic [1:0]       sync_q;
    tw_bus_ev_t       bus_ev;
    logic [PTR_W-1:0] rd_ptr;
    logic [7:0]       rd_byte;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_byte;

    tw_line_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (sync_q)
    );

    tw_cond_detect u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (sync_q[1]),
        .sda_s (sync_q[0]),
        .ev_o  (bus_ev)
    );

    tw_slave_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .DEPTH    (MEM_DEPTH)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (bus_ev),
        .rd_data_i  (rd_byte),
        .ptr_o      (rd_ptr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_byte),
        .sda_pull_o (sda_pull_o),
        .standby_o  (standby_o)
    );

    tw_regfile #(
        .DEPTH (MEM_DEPTH),
        .DW    (8)
    ) u_mem (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_byte),
        .rd_addr_i (rd_ptr),
        .rd_data_o (rd_byte)
    );

endmodule

// File: rtl/tw_pd_slave_chk.sv
// Property checker for tw_pd_slave, attached with the bind below.
// Assumes the synchronized clock level and the detected bus conditions
// are brought out of the top's internal nets.
module tw_pd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_pull_o,
    input logic standby_o
);

    // R10: the pull-down moves only while the bus clock is low.
    assert_pull_low_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

    // R8: a stop leads to standby with the line released.
    assert_stop_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (standby_o && !sda_pull_o));

    // R3: a start leaves standby.
    assert_start_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !standby_o);

    // R2: nothing is driven while in standby.
    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !sda_pull_o);

    // R9: a start, repeated or not, releases the line.
    assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_o);

endmodule

bind tw_pd_slave tw_pd_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (sync_q[1]),
    .start_det  (bus_ev.start),
    .stop_det   (bus_ev.stop),
    .sda_pull_o (sda_pull_o),
    .standby_o  (standby_o)
);

// File: tb/tw_pd_slave_test.sv
// Directed bench for tw_pd_slave: a bus master model, one task per scenario.
module tw_pd_slave_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic standby;
    logic sda_bus;
    int   checks = 0;
    int   errors = 0;
    int   r10_viol = 0;
    logic pull_prev = 1'b0;
    bit   done = 1'b0;

    localparam logic [7:0] DEV_WR = 8'hA0;  // address 0x50, write
    localparam logic [7:0] DEV_RD = 8'hA1;  // address 0x50, read

    always #2.5 clk = ~clk;  // 200 MHz

    assign sda_bus = m_sda & ~sda_pull;

    tw_pd_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .standby_o  (standby)
    );

    // R10 monitor: the pull-down must not move while the master holds SCL high.
    always @(negedge clk) begin
        if (rst_n && sda_pull != pull_prev && m_scl) r10_viol <= r10_viol + 1;
        pull_prev <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(10);
        m_sda = 1'b0; tick(10);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; tick(5);
        m_scl = 1'b1; tick(10);
        m_sda = 1'b1; tick(10);
    endtask

    // Master sends a byte MSB first, then samples the ninth-clock acknowledge.
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(5);
            m_scl = 1'b1; tick(10);
            m_scl = 1'b0; tick(5);
        end
        m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(5);
        acked = ~sda_bus;
        tick(5);
        m_scl = 1'b0; tick(5);
    endtask

    // Master reads a byte, then acknowledges it when host_ack is set.
    task automatic recv_byte(input bit host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(5);
            m_scl = 1'b1; tick(5);
            b[i] = sda_bus;
            tick(5);
            m_scl = 1'b0; tick(5);
        end
        m_sda = host_ack ? 1'b0 : 1'b1; tick(5);
        m_scl = 1'b1; tick(10);
        m_scl = 1'b0; tick(5);
        m_sda = 1'b1;
    endtask

    task automatic write_seq(input logic [7:0] waddr, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2);
        bit a;
        do_start();
        chk(standby == 1'b0, "R3 start clears standby", standby, 0);
        send_byte(DEV_WR, a);   chk(a, "R3 device byte ack", a, 1);
        send_byte(waddr, a);    chk(a, "R5 word pointer ack", a, 1);
        send_byte(d0, a);       chk(a, "R5 data ack", a, 1);
        send_byte(d1, a);       chk(a, "R5 data ack", a, 1);
        send_byte(d2, a);       chk(a, "R5 data ack", a, 1);
        do_stop();
        chk(standby == 1'b1, "R8 standby after stop", standby, 1);
        chk(sda_pull == 1'b0, "R8 line released after stop", sda_pull, 0);
    endtask

    // Sets the pointer with a write, then reads with a repeated start.
    task automatic read_seq(input logic [7:0] raddr, input int n,
                            input logic [7:0] e0, input logic [7:0] e1,
                            input logic [7:0] e2);
        bit a;
        logic [7:0] got;
        logic [7:0] exp_b;
        do_start();
        send_byte(DEV_WR, a);  chk(a, "R3 device byte ack", a, 1);
        send_byte(raddr, a);   chk(a, "R5 word pointer ack", a, 1);
        do_start();
        chk(standby == 1'b0, "R9 repeated start keeps standby low", standby, 0);
        send_byte(DEV_RD, a);  chk(a, "R9 device byte ack after restart", a, 1);
        for (int k = 0; k < n; k++) begin
            exp_b = (k == 0) ? e0 : (k == 1) ? e1 : e2;
            recv_byte(k != n - 1, got);
            chk(got == exp_b, "R6 read data", got, exp_b);
        end
        // R7: after the missing host acknowledge the slave stays silent.
        recv_byte(1'b0, got);
        chk(got == 8'hFF, "R7 silent after host nack", got, 8'hFF);
        do_stop();
        chk(standby == 1'b1, "R8 standby after read stop", standby, 1);
    endtask

    task automatic test_reset();
        chk(standby == 1'b1, "R1 standby after reset", standby, 1);
        chk(sda_pull == 1'b0, "R1 no pull after reset", sda_pull, 0);
    endtask

    task automatic test_no_start();
        bit a;
        m_scl = 1'b0; tick(5);
        send_byte(DEV_WR, a);
        chk(!a, "R2 no ack without start", a, 0);
        send_byte(8'h10, a);
        chk(!a, "R2 no ack without start", a, 0);
        chk(standby == 1'b1, "R2 standby kept without start", standby, 1);
    endtask

    task automatic test_write_read();
        write_seq(8'h10, 8'h5A, 8'hC3, 8'h0F);
        read_seq(8'h10, 3, 8'h5A, 8'hC3, 8'h0F);
    endtask

    task automatic test_wrap();
        write_seq(8'hFE, 8'h11, 8'h22, 8'h33);
        read_seq(8'hFE, 3, 8'h11, 8'h22, 8'h33);
        read_seq(8'h00, 1, 8'h33, 8'h00, 8'h00);
    endtask

    task automatic test_foreign_addr();
        bit a;
        do_start();
        send_byte(8'hA2, a);   chk(!a, "R4 foreign address not acked", a, 0);
        send_byte(8'h00, a);   chk(!a, "R4 later byte ignored", a, 0);
        send_byte(8'h77, a);   chk(!a, "R4 later byte ignored", a, 0);
        do_stop();
        // Bytes sent after the foreign address must not have changed 0x00 or 0x10.
        read_seq(8'h00, 1, 8'h33, 8'h00, 8'h00);
        read_seq(8'h10, 1, 8'h5A, 8'h00, 8'h00);
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(3);
        test_reset();
        test_no_start();
        test_write_read();
        test_wrap();
        test_foreign_addr();
        chk(r10_viol == 0, "R10 pull changes only with clock low", r10_viol, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule